// File: doc/BRIEF.md
# Idle-Triggered Clock Frequency Controller

This block watches a set of activity inputs from across the system and slows the bus and peripheral clock when everything has gone quiet. Once all activity inputs have stayed low for a programmable number of cycles, the block asks every attached IP block for permission to change the clock. It sets the divider output from divide-by-1 to divide-by-8 only after all of them have agreed. With a 96 MHz source this gives a 12 MHz idle clock. When any activity returns, it first raises the voltage-enable output and then runs the same handshake to go back to full speed.

No processor takes part in a switch. A normal handshake and switch takes a few tens of cycles. If any IP block does not acknowledge in time, the request is dropped and the clock stays where it was. The analog clock generator and the regulator sit outside the block. The block drives only the divider select and a voltage-enable level.

Top module: `idle_clock_governor`

## Requirements
- R1: Out of reset, all request outputs are low, the divider output is 1 (full speed) and voltage enable is high.
- R2: At full speed, a down request starts after the activity inputs have been all low for exactly `quiet_limit_i` consecutive cycles. A value of 0 counts as 1. Any high activity input restarts the count.
- R3: Requests to the IP blocks are all high or all low together. The divider output changes only in the cycle after every acknowledge input was seen high.
- R4: At the end of a down switch, the divider reads 8. The requests are released and voltage enable is lowered only after the switch completes, never earlier.
- R5: In the slow state, any high activity input raises voltage enable and all requests on the next cycle. The divider returns to 1 only after all acknowledges arrive and while voltage enable is already high.
- R6: If the acknowledges are not all high within TIMEOUT cycles (default 64) of the request, the requests are withdrawn and the divider keeps its current value. A withdrawn up request also lowers voltage enable again.
- R7: Activity that appears while a down request is pending cancels it on the next cycle, and the clock stays at full speed.
- R8: After the divider changes, the requests stay high for SETTLE cycles (default 12) and are then released. With prompt acknowledges, the whole sequence takes SETTLE+1 cycles.
- R9: A down switch produces this output sequence: requests raised, divider set to 8, then requests released with voltage enable lowered. An up switch produces: requests and voltage enable raised, divider set to 1, then requests released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| activity_i | input | NUM_ACT | Activity flags; any high bit means the system is busy |
| quiet_limit_i | input | CNT_W | Quiet cycles needed before slowing the clock |
| ip_ack_i | input | NUM_IP | Per-IP acknowledge of the switch request |
| ip_req_o | output | NUM_IP | Per-IP switch request, registered |
| clk_div_o | output | DIV_W | Divider select for the clock generator (1 or 8) |
| volt_en_o | output | 1 | Voltage-enable level for the regulator |

## Verification
Some rules are checked on every cycle, whatever the stimulus:
- the requests move as one group and the divider holds one of its two legal values;
- the divider never changes unless all acknowledges were high one cycle before;
- voltage enable falls only after the slow setting is in place, and the divider goes fast only while voltage enable is already high;
- no request window lasts longer than the timeout plus the settle time.

Other behaviour only the bench scenarios can show, because it depends on exact cycle counts and sequences:
- the exact quiet count, including the restart after an activity pulse and the limit of 1;
- the exact timeout length in both directions and the settle hold;
- the cancellation of a pending down request;
- the order of output changes in each kind of switch.

// File: rtl/icg_pkg.sv
package icg_pkg;
  typedef enum logic [2:0] {
    ST_RUN         = 3'd0,
    ST_REQ_DOWN    = 3'd1,
    ST_SWITCH_DOWN = 3'd2,
    ST_IDLE        = 3'd3,
    ST_REQ_UP      = 3'd4,
    ST_SWITCH_UP   = 3'd5
  } fstate_e;

  function automatic logic is_req_state(fstate_e s);
    return (s == ST_REQ_DOWN) || (s == ST_REQ_UP);
  endfunction

  function automatic logic is_switch_state(fstate_e s);
    return (s == ST_SWITCH_DOWN) || (s == ST_SWITCH_UP);
  endfunction

  function automatic logic is_slow_state(fstate_e s);
    return (s == ST_SWITCH_DOWN) || (s == ST_IDLE) || (s == ST_REQ_UP);
  endfunction
endpackage

// File: rtl/icg_quiet_timer.sv
// Counts consecutive quiet cycles while enabled; flags the last one.
module icg_quiet_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  // A limit of zero behaves as one because cnt_inc is never below 1.
  assign hit_o   = en_i & ~busy_i & (cnt_inc >= {1'b0, limit_i});

  always_ff @(posedge clk) begin
    if (rst || !en_i || busy_i || hit_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/icg_ack_gather.sv
// Combines per-IP acknowledges and times out a pending request.
module icg_ack_gather #(
  parameter int NUM_IP  = 3,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_i,
  input  logic [NUM_IP-1:0] ack_i,
  output logic              all_o,
  output logic              expire_o
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

  logic [TW-1:0]     tmo_q;
  logic [NUM_IP-1:0] ack_seen;

  // Per-IP qualification: an acknowledge only counts while a request is armed.
  for (genvar i = 0; i < NUM_IP; i++) begin : g_ack
    assign ack_seen[i] = arm_i & ack_i[i];
  end

  assign all_o    = &ack_seen;
  assign expire_o = arm_i & ~all_o & (tmo_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !arm_i) begin
      tmo_q <= '0;
    end else if (tmo_q != LAST) begin
      tmo_q <= tmo_q + 1'b1;
    end
  end
endmodule

// File: rtl/icg_freq_fsm.sv
// Sequencing of the clock switch and registered drive of all outputs.
module icg_freq_fsm
  import icg_pkg::*;
#(
  parameter int NUM_IP   = 3,
  parameter int DIV_W    = 4,
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 8,
  parameter int SETTLE   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake_i,
  input  logic              idle_hit_i,
  input  logic              all_ack_i,
  input  logic              expire_i,
  output fstate_e           state_o,
  output logic [NUM_IP-1:0] req_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              volt_o
);
  localparam int SW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE - 1);
  localparam logic [DIV_W-1:0] DIV_FAST = DIV_W'(FAST_DIV);
  localparam logic [DIV_W-1:0] DIV_SLOW = DIV_W'(SLOW_DIV);

  fstate_e       st_q, nxt;
  logic [SW-1:0] settle_q;
  logic          settle_done;
  logic          req_on;

  assign settle_done = is_switch_state(st_q) && (settle_q == SETTLE_LAST);

  always_comb begin
    nxt = st_q;
    case (st_q)
      ST_RUN:         if (idle_hit_i) nxt = ST_REQ_DOWN;
      ST_REQ_DOWN: begin
        if (wake_i)         nxt = ST_RUN;
        else if (all_ack_i) nxt = ST_SWITCH_DOWN;
        else if (expire_i)  nxt = ST_RUN;
      end
      ST_SWITCH_DOWN: if (settle_done) nxt = ST_IDLE;
      ST_IDLE:        if (wake_i) nxt = ST_REQ_UP;
      ST_REQ_UP: begin
        if (all_ack_i)     nxt = ST_SWITCH_UP;
        else if (expire_i) nxt = ST_IDLE;
      end
      ST_SWITCH_UP:   if (settle_done) nxt = ST_RUN;
      default:        nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      settle_q <= '0;
    end else begin
      st_q     <= nxt;
      settle_q <= is_switch_state(st_q) ? settle_q + 1'b1 : '0;
    end
  end

  assign req_on = is_req_state(nxt) || is_switch_state(nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o  <= DIV_FAST;
      volt_o <= 1'b1;
    end else begin
      div_o  <= is_slow_state(nxt) ? DIV_SLOW : DIV_FAST;
      volt_o <= (nxt != ST_IDLE);
    end
  end

  for (genvar i = 0; i < NUM_IP; i++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst) req_o[i] <= 1'b0;
      else     req_o[i] <= req_on;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/idle_clock_governor.sv
module idle_clock_governor
  import icg_pkg::*;
#(
  parameter int NUM_ACT  = 4,
  parameter int NUM_IP   = 3,
  parameter int CNT_W    = 16,
  parameter int DIV_W    = 4,
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 8,
  parameter int TIMEOUT  = 64,
  parameter int SETTLE   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ACT-1:0] activity_i,
  input  logic [CNT_W-1:0]   quiet_limit_i,
  input  logic [NUM_IP-1:0]  ip_ack_i,
  output logic [NUM_IP-1:0]  ip_req_o,
  output logic [DIV_W-1:0]   clk_div_o,
  output logic               volt_en_o
);
  fstate_e st;
  logic    wake, idle_hit, all_ack, expire;

  assign wake = |activity_i;

  icg_quiet_timer #(.CNT_W(CNT_W)) u_quiet (
    .clk     (clk),
    .rst     (rst),
    .en_i    (st == ST_RUN),
    .busy_i  (wake),
    .limit_i (quiet_limit_i),
    .hit_o   (idle_hit)
  );

  icg_ack_gather #(.NUM_IP(NUM_IP), .TIMEOUT(TIMEOUT)) u_ack (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (is_req_state(st)),
    .ack_i    (ip_ack_i),
    .all_o    (all_ack),
    .expire_o (expire)
  );

  icg_freq_fsm #(
    .NUM_IP(NUM_IP), .DIV_W(DIV_W), .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV), .SETTLE(SETTLE)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wake_i     (wake),
    .idle_hit_i (idle_hit),
    .all_ack_i  (all_ack),
    .expire_i   (expire),
    .state_o    (st),
    .req_o      (ip_req_o),
    .div_o      (clk_div_o),
    .volt_o     (volt_en_o)
  );
endmodule

// File: rtl/idle_clock_governor_chk.sv
module idle_clock_governor_chk #(
  parameter int NUM_IP   = 3,
  parameter int DIV_W    = 4,
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 8,
  parameter int TIMEOUT  = 64,
  parameter int SETTLE   = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_IP-1:0] ip_ack_i,
  input logic [NUM_IP-1:0] ip_req_o,
  input logic [DIV_W-1:0]  clk_div_o,
  input logic              volt_en_o
);
  localparam logic [DIV_W-1:0] DF = DIV_W'(FAST_DIV);
  localparam logic [DIV_W-1:0] DS = DIV_W'(SLOW_DIV);
  localparam logic [NUM_IP-1:0] ALL = {NUM_IP{1'b1}};

  logic [15:0] req_run;
  always_ff @(posedge clk) begin
    if (rst)            req_run <= '0;
    else if (|ip_req_o) req_run <= req_run + 1'b1;
    else                req_run <= '0;
  end

  a_r3_req_uniform: assert property (@(posedge clk) disable iff (rst)
    (ip_req_o == '0) || (ip_req_o == ALL));

  a_r3_div_legal: assert property (@(posedge clk) disable iff (rst)
    (clk_div_o == DF) || (clk_div_o == DS));

  a_r3_switch_needs_ack: assert property (@(posedge clk) disable iff (rst)
    (clk_div_o != $past(clk_div_o)) |-> (&$past(ip_ack_i)));

  a_r4_volt_drop_after_slow: assert property (@(posedge clk) disable iff (rst)
    $fell(volt_en_o) |-> (clk_div_o == DS) && ($past(clk_div_o) == DS));

  a_r4_no_req_when_volt_low: assert property (@(posedge clk) disable iff (rst)
    !volt_en_o |-> (ip_req_o == '0));

  a_r5_volt_before_fast: assert property (@(posedge clk) disable iff (rst)
    ((clk_div_o == DF) && ($past(clk_div_o) == DS)) |-> $past(volt_en_o));

  a_r6_request_window_bounded: assert property (@(posedge clk) disable iff (rst)
    req_run <= 16'(TIMEOUT + SETTLE));
endmodule

bind idle_clock_governor idle_clock_governor_chk #(
  .NUM_IP(NUM_IP), .DIV_W(DIV_W), .FAST_DIV(FAST_DIV),
  .SLOW_DIV(SLOW_DIV), .TIMEOUT(TIMEOUT), .SETTLE(SETTLE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ip_ack_i  (ip_ack_i),
  .ip_req_o  (ip_req_o),
  .clk_div_o (clk_div_o),
  .volt_en_o (volt_en_o)
);

// File: tb/idle_clock_governor_tb.sv
module idle_clock_governor_tb;
  localparam int NA = 4, NI = 3, CW = 16, DW = 4;
  localparam int TMO = 64, SET = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NA-1:0] activity = '1;
  logic [CW-1:0] limit = 16'd64;
  logic [NI-1:0] ip_ack = '0;
  logic [NI-1:0] ack_mask = '1;
  logic [NI-1:0] ip_req;
  logic [DW-1:0] div;
  logic          volt;

  int  n_cmp = 0, n_bad = 0;
  bit  done = 0, mon_on = 0;
  logic [5:0] exp_q[$];
  logic [5:0] cur, prev, e;

  always #2 clk = ~clk;

  idle_clock_governor u_dut (
    .clk(clk), .rst(rst), .activity_i(activity), .quiet_limit_i(limit),
    .ip_ack_i(ip_ack), .ip_req_o(ip_req), .clk_div_o(div), .volt_en_o(volt)
  );

  // IP models: acknowledge half a cycle after seeing the request.
  always @(negedge clk) ip_ack <= ip_req & ack_mask;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input bit r, input int d, input bit v);
    exp_q.push_back({r, 4'(d), v});
  endtask

  // Scoreboard monitor: each change of the output snapshot pops one expected item.
  always @(negedge clk) begin
    if (!rst && mon_on) begin
      cur = {|ip_req, div, volt};
      if (cur !== prev) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R9 sequence: actual %h expected none", cur);
        end else begin
          e = exp_q.pop_front();
          if (cur !== e) begin
            n_bad++;
            $display("FAIL R9 sequence: actual %h expected %h", cur, e);
          end
        end
        prev = cur;
      end
    end
  end

  task automatic count_to_req(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (ip_req == '0 && k < 5000);
  endtask

  task automatic measure(output int fast_n, output int slow_n);
    int guard = 0;
    fast_n = 0;
    slow_n = 0;
    while (ip_req != '0 && guard < 5000) begin
      if (div == 4'd1) fast_n++;
      else             slow_n++;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic push_down();
    push(1, 1, 1); push(1, 8, 1); push(0, 8, 0);
  endtask

  task automatic push_up();
    push(1, 8, 1); push(1, 1, 1); push(0, 1, 1);
  endtask

  initial begin
    int k, f, s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 requests after reset", int'(ip_req), 0);
    chk("R1 divider after reset", int'(div), 1);
    chk("R1 voltage after reset", int'(volt), 1);
    prev = {|ip_req, div, volt};
    mon_on = 1;

    // Quiet run interrupted by one pulse, then full down switch.
    push_down();
    activity = '0;
    repeat (30) @(negedge clk);
    activity = 4'b0100;
    @(negedge clk);
    activity = '0;
    count_to_req(k);
    chk("R2 quiet count 64 after restart", k, 64);
    chk("R3 all requests together", int'(ip_req), 7);
    measure(f, s);
    chk("R3 divider moves one cycle after acks", f, 1);
    chk("R8 settle hold on way down", s, SET);
    chk("R4 divider slow in idle", int'(div), 8);
    chk("R4 voltage low in idle", int'(volt), 0);

    // Wake up.
    push_up();
    activity = 4'b0001;
    @(negedge clk);
    chk("R5 requests on wake", int'(ip_req), 7);
    chk("R5 voltage raised before switch", int'(volt), 1);
    chk("R5 still slow while requesting", int'(div), 8);
    measure(f, s);
    chk("R5 one request cycle before fast", s, 1);
    chk("R8 settle hold on way up", f, SET);
    chk("R5 divider fast after wake", int'(div), 1);

    // Shorter limit, down switch, then an up request that times out.
    limit = 16'd20;
    push_down();
    activity = '0;
    count_to_req(k);
    chk("R2 quiet count 20", k, 20);
    measure(f, s);
    ack_mask = 3'b011;
    push(1, 8, 1); push(0, 8, 0);
    activity = 4'b1000;
    @(negedge clk);
    activity = '0;
    measure(f, s);
    chk("R6 up request window", s, TMO);
    chk("R6 divider kept slow", int'(div), 8);
    chk("R6 voltage dropped again", int'(volt), 0);

    // Wake properly, then a down request that times out.
    ack_mask = '1;
    push_up();
    activity = 4'b0001;
    @(negedge clk);
    measure(f, s);
    ack_mask = 3'b011;
    push(1, 1, 1); push(0, 1, 1);
    activity = '0;
    count_to_req(k);
    measure(f, s);
    activity = 4'b0001;
    chk("R6 down request window", f, TMO);
    chk("R6 divider kept fast", int'(div), 1);

    // Activity cancels a pending down request.
    ack_mask = '0;
    push(1, 1, 1); push(0, 1, 1);
    activity = '0;
    count_to_req(k);
    repeat (5) @(negedge clk);
    activity = 4'b0010;
    @(negedge clk);
    chk("R7 request cancelled", int'(ip_req), 0);
    chk("R7 divider stays fast", int'(div), 1);

    // Limit of one.
    ack_mask = '1;
    limit = 16'd1;
    push_down();
    activity = '0;
    count_to_req(k);
    chk("R2 limit one", k, 1);
    measure(f, s);
    chk("R4 voltage low after short idle", int'(volt), 0);

    repeat (4) @(negedge clk);
    chk("R9 all expected items seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule